// File: doc/BRIEF.md
# Dual Smart Card Signal Router

This block sits between a host controller and two smart card slots, A and B. It carries the reset, C4 and C8 control lines and the serial I/O line to each card. Analog level translation, pull-up resistors and card supply generation are not part of it. They appear here only as digital status inputs and one enable output. Every card-side signal is registered, so each card output changes on the clock edge after the cause appears at the inputs.

The mode input picks one of two routings. With the mode low, each card has its own set of host inputs and both cards are driven at the same time. With the mode high, only the channel A host inputs are used. They are steered to card A when the card-select input is low and to card B when it is high, and the channel B host inputs are ignored.

Each card's control outputs follow the host while that card is selected. They hold their value when a rising edge appears on the card-select, chip-select or programming strobe, and while the card is not selected. A supply-low flag, or a card's own start-up flag, forces that card's outputs to zero and clears the held value.

Top module: `sc_dual_router`

## Requirements
- R1: While reset is asserted, all card control outputs, card I/O outputs, card I/O enables and host I/O inputs are 0.
- R2: A channel is selected when chip-select is low and either the mode is low or card-select picks it (low picks A, high picks B). A selected channel with no strobe rising edge and no fault copies its host control bits (bit 0 reset, bit 1 C4, bit 2 C8) to its card outputs one clock later.
- R3: In a cycle where card-select, chip-select or the programming strobe rises, the card control outputs keep their previous value. A strobe that stays high has no effect.
- R4: A channel that is not selected keeps its card control outputs unchanged.
- R5: When the supply-low flag, or a channel's start-up flag, is high, that channel's control outputs and card I/O output go to 0 and its card I/O enable goes to 1 one clock later. The held control value stays 0 until the channel tracks again.
- R6: While chip-select is high, card I/O outputs, card I/O enables and host I/O inputs keep their previous values.
- R7: With the mode low, card B follows the channel B host inputs at the same time as card A follows the channel A host inputs.
- R8: With the mode high, the channel A host inputs drive the card picked by card-select, the other card holds, and the channel B host inputs have no effect.
- R9: With the mode high, host I/O input A returns the selected card's I/O line one clock later, and host I/O input B reads 1.
- R10: The pull-up disconnect output equals the mode input with no clock delay.
- R11: A selected, fault-free channel with chip-select low passes the host I/O value and enable to the card, and the card I/O line to the host, one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| muxMode | input | 1 | 1 = shared host channel, 0 = independent channels |
| cardSel | input | 1 | Card pick in shared mode (1 = B); latch strobe |
| chipSel | input | 1 | High deselects both cards and freezes I/O; latch strobe |
| progStrobe | input | 1 | Programming strobe; rising edge latches |
| supplyLow | input | 1 | Host supply below threshold |
| startupA | input | 1 | Card A supply in start-up |
| startupB | input | 1 | Card B supply in start-up |
| hostCtlA | input | CTL_W | Host control bits, channel A |
| hostCtlB | input | CTL_W | Host control bits, channel B |
| hostIoOutA | input | 1 | Host I/O value toward card, channel A |
| hostIoOeA | input | 1 | Host drives I/O, channel A |
| hostIoInA | output | 1 | Card I/O value returned to host, channel A |
| hostIoOutB | input | 1 | Host I/O value toward card, channel B |
| hostIoOeB | input | 1 | Host drives I/O, channel B |
| hostIoInB | output | 1 | Card I/O value returned to host, channel B |
| cardCtlA | output | CTL_W | Card A control bits |
| cardCtlB | output | CTL_W | Card B control bits |
| cardIoOutA | output | 1 | I/O value driven to card A |
| cardIoOeA | output | 1 | Drive enable toward card A |
| cardIoInA | input | 1 | I/O value read from card A |
| cardIoOutB | output | 1 | I/O value driven to card B |
| cardIoOeB | output | 1 | Drive enable toward card B |
| cardIoInB | input | 1 | I/O value read from card B |
| pullupOffA | output | 1 | Disconnects the channel A host-side pull-up |

## Verification
Every card output and host I/O input is due exactly one clock after its inputs are presented. Strobe edges are judged against the level held in the previous cycle, so the cycle that decides whether an output holds is the one where the strobe rises. The bench changes inputs on the falling edge and compares on the next falling edge, which is half a period after the register update. The pull-up disconnect output has no delay, so it is compared a short time after the mode input changes.

// File: rtl/sc_route_pkg.sv
package sc_route_pkg;
  localparam int NUM_CARDS = 2;

  typedef struct packed {
    logic clear;    // fault: force zero
    logic track;    // control bits follow source
    logic ioTrack;  // I/O path follows source
  } chanCtl_t;

  typedef struct packed {
    chanCtl_t [NUM_CARDS-1:0] ch;
    logic shared;   // one host channel for both cards
    logic pickB;    // shared channel steered to card B
  } routeCtl_t;
endpackage

// File: rtl/sc_route_ctrl.sv
module sc_route_ctrl
  import sc_route_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 muxMode,
  input  logic                 cardSel,
  input  logic                 chipSel,
  input  logic                 progStrobe,
  input  logic                 supplyLow,
  input  logic [NUM_CARDS-1:0] startup,
  output routeCtl_t            ctl
);
  logic prevSel, prevCs, prevProg;
  logic latchEvt;
  logic [NUM_CARDS-1:0] picked;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSel  <= 1'b0;
      prevCs   <= 1'b0;
      prevProg <= 1'b0;
    end else begin
      prevSel  <= cardSel;
      prevCs   <= chipSel;
      prevProg <= progStrobe;
    end
  end

  assign latchEvt = (cardSel & ~prevSel) | (chipSel & ~prevCs) | (progStrobe & ~prevProg);
  assign picked[0] = ~muxMode | ~cardSel;
  assign picked[1] = ~muxMode | cardSel;

  always_comb begin
    ctl.shared = muxMode;
    ctl.pickB  = cardSel;
    for (int k = 0; k < NUM_CARDS; k++) begin
      ctl.ch[k].clear   = supplyLow | startup[k];
      ctl.ch[k].ioTrack = ~chipSel & picked[k] & ~ctl.ch[k].clear;
      ctl.ch[k].track   = ctl.ch[k].ioTrack & ~latchEvt;
    end
  end

  // R3: a rising chip-select stops tracking on both channels
  assert_cs_edge_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    (chipSel && !$past(chipSel)) |-> (!ctl.ch[0].track && !ctl.ch[1].track));
  // R8: in shared mode at most one card's path is live
  assert_shared_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    muxMode |-> !(ctl.ch[0].ioTrack && ctl.ch[1].ioTrack));
  // R5: supply low clears both channels
  assert_supply_low_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    supplyLow |-> (ctl.ch[0].clear && ctl.ch[1].clear));
endmodule

// File: rtl/sc_route_dp.sv
module sc_route_dp
  import sc_route_pkg::*;
#(
  parameter int CTL_W = 3
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  routeCtl_t                        ctl,
  input  logic [NUM_CARDS-1:0][CTL_W-1:0]  hostCtl,
  input  logic [NUM_CARDS-1:0]             hostIoOut,
  input  logic [NUM_CARDS-1:0]             hostIoOe,
  input  logic [NUM_CARDS-1:0]             cardIoIn,
  output logic [NUM_CARDS-1:0][CTL_W-1:0]  cardCtl,
  output logic [NUM_CARDS-1:0]             cardIoOut,
  output logic [NUM_CARDS-1:0]             cardIoOe,
  output logic [NUM_CARDS-1:0]             hostIoIn
);
  logic [NUM_CARDS-1:0][CTL_W-1:0] srcCtl;
  logic [NUM_CARDS-1:0]            srcIo, srcOe;

  for (genvar k = 0; k < NUM_CARDS; k++) begin : g_card
    if (k == 0) begin : g_own
      assign srcCtl[k] = hostCtl[0];
      assign srcIo[k]  = hostIoOut[0];
      assign srcOe[k]  = hostIoOe[0];
    end else begin : g_steer
      assign srcCtl[k] = ctl.shared ? hostCtl[0]   : hostCtl[k];
      assign srcIo[k]  = ctl.shared ? hostIoOut[0] : hostIoOut[k];
      assign srcOe[k]  = ctl.shared ? hostIoOe[0]  : hostIoOe[k];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cardCtl[k]   <= '0;
        cardIoOut[k] <= 1'b0;
        cardIoOe[k]  <= 1'b0;
      end else if (ctl.ch[k].clear) begin
        cardCtl[k]   <= '0;
        cardIoOut[k] <= 1'b0;
        cardIoOe[k]  <= 1'b1;
      end else begin
        if (ctl.ch[k].track)   cardCtl[k] <= srcCtl[k];
        if (ctl.ch[k].ioTrack) begin
          cardIoOut[k] <= srcIo[k];
          cardIoOe[k]  <= srcOe[k];
        end
      end
    end

    if (k == 0) begin : g_ret_a
      always_ff @(posedge clk) begin
        if (!rstN)                               hostIoIn[k] <= 1'b0;
        else if (ctl.ch[0].ioTrack)              hostIoIn[k] <= cardIoIn[0];
        else if (ctl.shared && ctl.ch[1].ioTrack) hostIoIn[k] <= cardIoIn[1];
      end
    end else begin : g_ret_b
      always_ff @(posedge clk) begin
        if (!rstN)                  hostIoIn[k] <= 1'b0;
        else if (ctl.shared)        hostIoIn[k] <= 1'b1;
        else if (ctl.ch[k].ioTrack) hostIoIn[k] <= cardIoIn[k];
      end
    end

    // R5: fault drives the card side to zero
    assert_fault_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
      ctl.ch[k].clear |=> (cardCtl[k] == '0 && !cardIoOut[k] && cardIoOe[k]));
    // R4: without tracking the control bits stay put
    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
      (!ctl.ch[k].clear && !ctl.ch[k].track) |=> $stable(cardCtl[k]));
    // R2: tracking copies the steered host bits
    assert_track_copy_R2: assert property (@(posedge clk) disable iff (!rstN)
      ctl.ch[k].track |=> (cardCtl[k] == $past(srcCtl[k])));
    // R6: frozen I/O path keeps its value
    assert_io_freeze_R6: assert property (@(posedge clk) disable iff (!rstN)
      (!ctl.ch[k].clear && !ctl.ch[k].ioTrack) |=> ($stable(cardIoOut[k]) && $stable(cardIoOe[k])));
  end

  // R9: shared mode returns 1 on host channel B
  assert_b_return_high_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shared |=> hostIoIn[1]);
endmodule

// File: rtl/sc_dual_router.sv
module sc_dual_router
  import sc_route_pkg::*;
#(
  parameter int CTL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             muxMode,
  input  logic             cardSel,
  input  logic             chipSel,
  input  logic             progStrobe,
  input  logic             supplyLow,
  input  logic             startupA,
  input  logic             startupB,
  input  logic [CTL_W-1:0] hostCtlA,
  input  logic [CTL_W-1:0] hostCtlB,
  input  logic             hostIoOutA,
  input  logic             hostIoOeA,
  output logic             hostIoInA,
  input  logic             hostIoOutB,
  input  logic             hostIoOeB,
  output logic             hostIoInB,
  output logic [CTL_W-1:0] cardCtlA,
  output logic [CTL_W-1:0] cardCtlB,
  output logic             cardIoOutA,
  output logic             cardIoOeA,
  input  logic             cardIoInA,
  output logic             cardIoOutB,
  output logic             cardIoOeB,
  input  logic             cardIoInB,
  output logic             pullupOffA
);
  routeCtl_t                       routeCtl;
  logic [NUM_CARDS-1:0][CTL_W-1:0] hostCtlV, cardCtlV;
  logic [NUM_CARDS-1:0]            ioOutV, ioOeV, ioInV, cardOutV, cardOeV, hostInV;

  assign hostCtlV = {hostCtlB, hostCtlA};
  assign ioOutV   = {hostIoOutB, hostIoOutA};
  assign ioOeV    = {hostIoOeB, hostIoOeA};
  assign ioInV    = {cardIoInB, cardIoInA};

  sc_route_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .muxMode(muxMode), .cardSel(cardSel),
    .chipSel(chipSel), .progStrobe(progStrobe), .supplyLow(supplyLow),
    .startup({startupB, startupA}), .ctl(routeCtl)
  );

  sc_route_dp #(.CTL_W(CTL_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(routeCtl), .hostCtl(hostCtlV),
    .hostIoOut(ioOutV), .hostIoOe(ioOeV), .cardIoIn(ioInV),
    .cardCtl(cardCtlV), .cardIoOut(cardOutV), .cardIoOe(cardOeV), .hostIoIn(hostInV)
  );

  assign cardCtlA   = cardCtlV[0];
  assign cardCtlB   = cardCtlV[1];
  assign cardIoOutA = cardOutV[0];
  assign cardIoOutB = cardOutV[1];
  assign cardIoOeA  = cardOeV[0];
  assign cardIoOeB  = cardOeV[1];
  assign hostIoInA  = hostInV[0];
  assign hostIoInB  = hostInV[1];
  assign pullupOffA = muxMode;
endmodule

// File: tb/sim_sc_dual_router.sv
`timescale 1ns/1ps
module sim_sc_dual_router;
  localparam int CTL_W = 3;
  localparam int NVEC  = 18;
  // {mux,sel,cs,prog,sup,stA,stB, hostA, hostB, expA, expB}
  localparam logic [18:0] VEC [NVEC] = '{
    19'b0_0_0_0_0_0_0_101_011_101_011,  // R2 R7
    19'b0_0_0_0_0_0_0_110_001_110_001,  // R2 R7
    19'b0_0_0_1_0_0_0_111_111_110_001,  // R3 prog rises
    19'b0_0_0_1_0_0_0_111_111_111_111,  // R3 prog held
    19'b0_0_1_0_0_0_0_000_000_111_111,  // R3 cs rises
    19'b0_0_1_0_0_0_0_010_100_111_111,  // R4 cs high
    19'b0_0_0_0_0_0_0_010_100_010_100,  // R2
    19'b0_1_0_0_0_0_0_001_001_010_100,  // R3 sel rises
    19'b0_1_0_0_0_0_0_001_110_001_110,  // R7
    19'b1_0_0_0_0_0_0_100_111_100_110,  // R8 pick A
    19'b1_1_0_0_0_0_0_011_000_100_110,  // R3 sel rises
    19'b1_1_0_0_0_0_0_011_000_100_011,  // R8 pick B
    19'b1_1_0_0_0_0_0_101_010_100_101,  // R8 host B ignored
    19'b1_0_0_0_0_0_0_010_111_010_101,  // R8 back to A
    19'b0_0_0_0_1_0_0_111_111_000_000,  // R5 supply low
    19'b0_0_0_0_0_1_0_111_011_000_011,  // R5 start-up A
    19'b0_0_1_0_0_0_1_101_101_000_000,  // R5 cleared value held
    19'b0_0_0_0_0_0_0_101_110_101_110   // R2 resume
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic muxMode = 0, cardSel = 0, chipSel = 0, progStrobe = 0, supplyLow = 0;
  logic startupA = 0, startupB = 0;
  logic [CTL_W-1:0] hostCtlA = '0, hostCtlB = '0, cardCtlA, cardCtlB;
  logic hostIoOutA = 0, hostIoOeA = 0, hostIoOutB = 0, hostIoOeB = 0;
  logic cardIoInA = 0, cardIoInB = 0;
  logic hostIoInA, hostIoInB, cardIoOutA, cardIoOeA, cardIoOutB, cardIoOeB, pullupOffA;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sc_dual_router #(.CTL_W(CTL_W)) u0 (
    .clk(clk), .rstN(rstN), .muxMode(muxMode), .cardSel(cardSel), .chipSel(chipSel),
    .progStrobe(progStrobe), .supplyLow(supplyLow), .startupA(startupA), .startupB(startupB),
    .hostCtlA(hostCtlA), .hostCtlB(hostCtlB), .hostIoOutA(hostIoOutA), .hostIoOeA(hostIoOeA),
    .hostIoInA(hostIoInA), .hostIoOutB(hostIoOutB), .hostIoOeB(hostIoOeB), .hostIoInB(hostIoInB),
    .cardCtlA(cardCtlA), .cardCtlB(cardCtlB), .cardIoOutA(cardIoOutA), .cardIoOeA(cardIoOeA),
    .cardIoInA(cardIoInA), .cardIoOutB(cardIoOutB), .cardIoOeB(cardIoOeB), .cardIoInB(cardIoInB),
    .pullupOffA(pullupOffA)
  );

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "ctlA", 8'(cardCtlA), 8'h0);
    check("R1", "ctlB", 8'(cardCtlB), 8'h0);
    check("R1", "io", {4'h0, cardIoOutA, cardIoOeA, cardIoOutB, cardIoOeB}, 8'h0);
    check("R1", "hostIn", {6'h0, hostIoInA, hostIoInB}, 8'h0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      {muxMode, cardSel, chipSel, progStrobe, supplyLow, startupA, startupB} = VEC[i][18:12];
      hostCtlA = VEC[i][11:9];
      hostCtlB = VEC[i][8:6];
      @(negedge clk);
      check("R2/R3/R4/R5/R7/R8", $sformatf("vec %0d cardA", i), 8'(cardCtlA), 8'(VEC[i][5:3]));
      check("R2/R3/R4/R5/R7/R8", $sformatf("vec %0d cardB", i), 8'(cardCtlB), 8'(VEC[i][2:0]));
    end

    // R11: independent I/O paths
    {muxMode, cardSel, chipSel, progStrobe, supplyLow, startupA, startupB} = '0;
    hostIoOutA = 1; hostIoOeA = 1; hostIoOutB = 0; hostIoOeB = 1;
    cardIoInA = 0; cardIoInB = 1;
    #1 check("R10", "pullup demux", 8'(pullupOffA), 8'h0);
    @(negedge clk);
    check("R11", "cardA io", {6'h0, cardIoOutA, cardIoOeA}, 8'h3);
    check("R11", "cardB io", {6'h0, cardIoOutB, cardIoOeB}, 8'h1);
    check("R11", "hostIn", {6'h0, hostIoInA, hostIoInB}, 8'h1);

    // R6: chip-select freezes I/O
    chipSel = 1; hostIoOutA = 0; hostIoOeA = 0; cardIoInA = 1;
    @(negedge clk);
    check("R6", "cardA io", {6'h0, cardIoOutA, cardIoOeA}, 8'h3);
    check("R6", "hostInA", 8'(hostIoInA), 8'h0);

    chipSel = 0;
    @(negedge clk);
    check("R11", "cardA io resume", {6'h0, cardIoOutA, cardIoOeA}, 8'h0);
    check("R11", "hostInA resume", 8'(hostIoInA), 8'h1);

    // R9: shared mode, card B picked
    muxMode = 1; cardSel = 1; hostIoOutA = 1; hostIoOeA = 1; hostIoOutB = 0; hostIoOeB = 0;
    cardIoInA = 0; cardIoInB = 1;
    #1 check("R10", "pullup mux", 8'(pullupOffA), 8'h1);
    @(negedge clk);
    check("R8", "cardB io", {6'h0, cardIoOutB, cardIoOeB}, 8'h3);
    check("R8", "cardA io hold", {6'h0, cardIoOutA, cardIoOeA}, 8'h0);
    check("R9", "hostIn", {6'h0, hostIoInA, hostIoInB}, 8'h3);

    // R9: shared mode, card A picked; host B inputs ignored
    cardSel = 0; cardIoInA = 0; cardIoInB = 1;
    @(negedge clk);
    check("R8", "cardA io", {6'h0, cardIoOutA, cardIoOeA}, 8'h3);
    check("R8", "cardB io hold", {6'h0, cardIoOutB, cardIoOeB}, 8'h3);
    check("R9", "hostIn", {6'h0, hostIoInA, hostIoInB}, 8'h1);

    // R5: fault forces I/O low and driven
    muxMode = 0; supplyLow = 1;
    @(negedge clk);
    check("R5", "io fault", {4'h0, cardIoOutA, cardIoOeA, cardIoOutB, cardIoOeB}, 8'h5);
    check("R5", "ctl fault", {2'h0, cardCtlA, cardCtlB}, 8'h0);

    finish_run();
  end
endmodule